// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block decides when a CAN controller enters and leaves the Bus-Off state. A single overflow signal from the transmit error counter places the controller in Bus-Off. When that happens the block forces the initialization flag high and withholds the bus-enable output, so all bus traffic stops. Nothing further happens until software writes the flag back to zero.

After that release the block counts idle occurrences on the sampled receive bit. One occurrence is a run of consecutive recessive samples, 11 by default, and recovery needs 129 of them. Each completed occurrence writes the Bit0 code into the last-error-code output and pulses a write strobe, so software can follow the progress of recovery or see a bus held dominant. When the final occurrence completes, the block pulses a clear to both error counters and returns to normal operation. Software writes to the flag during recovery change the flag, but they neither shorten nor restart the count.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, init_flag is 1 and bus_off, bus_en, lec_wr and err_clr are 0. lec_code holds 3'b111, meaning no code has been written.
- R2: Outside Bus-Off, an init_wr pulse loads init_wdata into init_flag on the next cycle. bus_en equals the inverse of init_flag.
- R3: tec_ovf high while not Bus-Off sets bus_off and init_flag on the next cycle. It takes priority over an init write in the same cycle.
- R4: While Bus-Off and not yet released, writing 1 to the flag, tec_ovf and any bit samples have no effect: bus_off and init_flag stay at 1 and lec_wr stays at 0.
- R5: Once software writes 0 to the flag in Bus-Off, every 11 consecutive recessive samples (rx_bit=1 with bit_tick=1) complete one run. In the cycle after the 11th sample, lec_wr is 1 for one cycle and lec_code is the Bit0 code 3'b101.
- R6: A dominant sample (rx_bit=0 with bit_tick=1) during recovery restarts the current run from zero. Runs already completed are kept.
- R7: The 129th completed run ends recovery. bus_off falls and err_clr is 1 for exactly that one cycle, the same cycle as the last lec_wr. On a bus that stays recessive, this is 1419 samples after the release.
- R8: Writes to the flag during recovery update init_flag but do not change the run count. After recovery, bus_en is the inverse of whatever init_flag value was written last.
- R9: Cycles with bit_tick low do not advance recovery, whatever rx_bit is.
- R10: bus_en is never 1 while bus_off is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking a valid bus sample |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| tec_ovf | input | 1 | Transmit error counter overflowed past 255 |
| init_wr | input | 1 | Software write strobe for the init flag |
| init_wdata | input | 1 | Value written to the init flag |
| init_flag | output | 1 | Current initialization flag |
| bus_off | output | 1 | Controller is Bus-Off (halted or recovering) |
| bus_en | output | 1 | Bus activity allowed |
| err_clr | output | 1 | One-cycle clear of both error counters |
| lec_code | output | 3 | Last error code field |
| lec_wr | output | 1 | One-cycle strobe for each completed idle run |

## Verification
On every cycle the assertions check these relations: Bus-Off entry on overflow, flag loading in normal operation, bus_en staying low during Bus-Off, single-cycle lec_wr pulses carrying the Bit0 code, no posting without a sample, and err_clr coinciding with the fall of bus_off. Only the bench scenarios can show the counts: 11 samples per run, dominant restarts that keep earlier runs, 1419 samples on a recessive bus, and writes made during recovery leaving its length unchanged.

// File: rtl/bor_pkg.sv
package bor_pkg;
   typedef enum logic [1:0] {
      BOR_NORMAL  = 2'd0,
      BOR_HALT    = 2'd1,
      BOR_RECOVER = 2'd2
   } bor_state_e;

   localparam logic [2:0] BOR_CODE_BIT0 = 3'b101;
   localparam logic [2:0] BOR_CODE_NONE = 3'b111;
endpackage

// File: rtl/bor_step_cnt.sv
// Wrapping event counter: counts adv pulses up to LIMIT, flags the wrap.
module bor_step_cnt #(
   parameter int LIMIT = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   input  logic zero,
   output logic done
);
   localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("bor_step_cnt: LIMIT must be at least 1");
      end
      if (LIMIT == 1) begin : g_single
         assign done = adv && !zero && !clr;
      end else begin : g_count
         logic [W-1:0] cnt_q;
         logic         at_last;

         assign at_last = (cnt_q == W'(LIMIT - 1));
         assign done    = adv && !zero && !clr && at_last;

         always_ff @(posedge clk) begin
            if (!rst_n || clr || zero) begin
               cnt_q <= '0;
            end else if (adv) begin
               cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bor_code_post.sv
// Holds the last error code and pulses a strobe on each post.
module bor_code_post #(
   parameter int               LEC_W = 3,
   parameter logic [LEC_W-1:0] CODE  = 3'b101,
   parameter logic [LEC_W-1:0] IDLE  = 3'b111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             post,
   output logic [LEC_W-1:0] code,
   output logic             wr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= IDLE;
         wr   <= 1'b0;
      end else begin
         wr <= post;
         if (post) code <= CODE;
      end
   end
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery
   import bor_pkg::*;
#(
   parameter int               RUN_LEN   = 11,
   parameter int               IDLE_RUNS = 129,
   parameter int               LEC_W     = 3,
   parameter logic [LEC_W-1:0] LEC_BIT0  = BOR_CODE_BIT0,
   parameter logic [LEC_W-1:0] LEC_INIT  = BOR_CODE_NONE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             rx_bit,
   input  logic             tec_ovf,
   input  logic             init_wr,
   input  logic             init_wdata,
   output logic             init_flag,
   output logic             bus_off,
   output logic             bus_en,
   output logic             err_clr,
   output logic [LEC_W-1:0] lec_code,
   output logic             lec_wr
);
   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("can_busoff_recovery: RUN_LEN must be at least 2");
      end
      if (IDLE_RUNS < 1) begin : g_bad_idle
         $error("can_busoff_recovery: IDLE_RUNS must be at least 1");
      end
      if (LEC_BIT0 == LEC_INIT) begin : g_bad_code
         $error("can_busoff_recovery: Bit0 code must differ from reset code");
      end
   endgenerate

   bor_state_e st_q;
   logic       init_q;
   logic       clr_q;
   logic       recovering;
   logic       run_done;
   logic       idle_done;

   assign recovering = (st_q == BOR_RECOVER);

   bor_step_cnt #(.LIMIT(RUN_LEN)) u_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!recovering),
      .adv   (bit_tick),
      .zero  (bit_tick && !rx_bit),
      .done  (run_done)
   );

   bor_step_cnt #(.LIMIT(IDLE_RUNS)) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!recovering),
      .adv   (run_done),
      .zero  (1'b0),
      .done  (idle_done)
   );

   bor_code_post #(.LEC_W(LEC_W), .CODE(LEC_BIT0), .IDLE(LEC_INIT)) u_lec (
      .clk   (clk),
      .rst_n (rst_n),
      .post  (run_done),
      .code  (lec_code),
      .wr    (lec_wr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= BOR_NORMAL;
         init_q <= 1'b1;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         unique case (st_q)
            BOR_NORMAL: begin
               if (tec_ovf) begin
                  st_q   <= BOR_HALT;
                  init_q <= 1'b1;
               end else if (init_wr) begin
                  init_q <= init_wdata;
               end
            end
            BOR_HALT: begin
               if (init_wr && !init_wdata) begin
                  init_q <= 1'b0;
                  st_q   <= BOR_RECOVER;
               end
            end
            BOR_RECOVER: begin
               if (init_wr) init_q <= init_wdata;
               if (idle_done) begin
                  st_q  <= BOR_NORMAL;
                  clr_q <= 1'b1;
               end
            end
            default: st_q <= BOR_NORMAL;
         endcase
      end
   end

   assign init_flag = init_q;
   assign bus_off   = (st_q != BOR_NORMAL);
   assign bus_en    = (st_q == BOR_NORMAL) && !init_q;
   assign err_clr   = clr_q;
endmodule

// File: rtl/bor_checker.sv
module bor_checker #(
   parameter int               LEC_W    = 3,
   parameter logic [LEC_W-1:0] LEC_BIT0 = 3'b101
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_tick,
   input logic             rx_bit,
   input logic             tec_ovf,
   input logic             init_wr,
   input logic             init_wdata,
   input logic             init_flag,
   input logic             bus_off,
   input logic             bus_en,
   input logic             err_clr,
   input logic [LEC_W-1:0] lec_code,
   input logic             lec_wr
);
   assert_overflow_enters_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_off && tec_ovf) |=> (bus_off && init_flag));

   assert_flag_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_off && !tec_ovf && init_wr) |=> (init_flag == $past(init_wdata)));

   assert_no_bus_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_off |-> !bus_en);

   assert_post_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lec_wr |-> (lec_code == LEC_BIT0));

   assert_post_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lec_wr |=> !lec_wr);

   assert_no_tick_no_post_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> !lec_wr);

   assert_clear_at_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |-> (lec_wr && !bus_off && $past(bus_off)));

   assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_off) |-> err_clr);

   assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !err_clr);
endmodule

bind can_busoff_recovery bor_checker #(.LEC_W(LEC_W), .LEC_BIT0(LEC_BIT0)) chk_i (.*);

// File: tb/can_busoff_recovery_tb_top.sv
module can_busoff_recovery_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0, rx_bit = 1'b1, tec_ovf = 1'b0;
   logic       init_wr = 1'b0, init_wdata = 1'b0;
   logic       init_flag, bus_off, bus_en, err_clr, lec_wr;
   logic [2:0] lec_code;

   always #5 clk = ~clk;

   can_busoff_recovery dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_bit(rx_bit),
      .tec_ovf(tec_ovf), .init_wr(init_wr), .init_wdata(init_wdata),
      .init_flag(init_flag), .bus_off(bus_off), .bus_en(bus_en),
      .err_clr(err_clr), .lec_code(lec_code), .lec_wr(lec_wr)
   );

   int checks = 0, errors = 0, cycles = 0, pulses = 0;
   bit done_flag = 0;

   // expected-state model: 0 normal, 1 halted, 2 recovering
   int m_st = 0, m_run = 0, m_idle = 0;
   bit m_init = 1, m_lecwr = 0, m_clr = 0;
   logic [2:0] m_lec = 3'b111;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
      end
   endtask

   function automatic void model_step(bit t, bit r, bit o, bit w, bit v);
      m_lecwr = 0;
      m_clr   = 0;
      case (m_st)
         0: if (o) begin m_st = 1; m_init = 1; end
            else if (w) m_init = v;
         1: if (w && !v) begin m_init = 0; m_st = 2; end
         default: begin
            if (t) begin
               if (!r) m_run = 0;
               else if (m_run == 10) begin
                  m_run = 0; m_lecwr = 1; m_lec = 3'b101;
                  if (m_idle == 128) begin m_idle = 0; m_st = 0; m_clr = 1; end
                  else m_idle++;
               end else m_run++;
            end
            if (w) m_init = v;
         end
      endcase
   endfunction

   task automatic step(bit t, bit r, bit o, bit w, bit v);
      bit_tick = t; rx_bit = r; tec_ovf = o; init_wr = w; init_wdata = v;
      @(posedge clk);
      model_step(t, r, o, w, v);
      @(negedge clk);
      cycles++;
      if (lec_wr) pulses++;
      chk("R3 bus_off", int'(bus_off), int'(m_st != 0));
      chk("R2 init_flag", int'(init_flag), int'(m_init));
      chk("R10 bus_en", int'(bus_en), int'(m_st == 0 && !m_init));
      chk("R5 lec_wr", int'(lec_wr), int'(m_lecwr));
      chk("R5 lec_code", int'(lec_code), int'(m_lec));
      chk("R7 err_clr", int'(err_clr), int'(m_clr));
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cycles > 150000 && !done_flag) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
         finish_run();
      end
   end

   initial begin
      int n, p0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 init_flag", int'(init_flag), 1);
      chk("R1 bus_off", int'(bus_off), 0);
      chk("R1 bus_en", int'(bus_en), 0);
      chk("R1 lec_code", int'(lec_code), 7);
      chk("R1 lec_wr", int'(lec_wr), 0);
      chk("R1 err_clr", int'(err_clr), 0);

      // R2 software control in normal operation
      step(0, 1, 0, 1, 0);
      chk("R2 bus_en after clear", int'(bus_en), 1);
      step(1, 1, 0, 1, 1);
      step(1, 1, 0, 1, 0);

      // R3 overflow wins over same-cycle write of 0
      step(0, 1, 1, 1, 0);
      chk("R3 entered", int'(bus_off && init_flag), 1);

      // R4 halted: writes of 1, overflow and recessive ticks ignored
      p0 = pulses;
      for (int i = 0; i < 30; i++) step(1, 1, (i % 7) == 0, (i % 5) == 0, 1);
      chk("R4 no posts while halted", pulses - p0, 0);
      chk("R4 still off", int'(bus_off && init_flag), 1);

      // release, then R6: dominant restart keeps nothing extra
      step(0, 1, 0, 1, 0);
      p0 = pulses;
      for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0);
      chk("R6 no post after restart", pulses - p0, 0);
      // R9 no tick, bus toggling
      for (int i = 0; i < 8; i++) step(0, i[0], 0, 0, 0);
      chk("R9 no post without tick", pulses - p0, 0);
      step(1, 1, 0, 0, 0);
      chk("R6 post on 11th", int'(lec_wr), 1);

      // random recovery with software writes (R8)
      p0 = pulses - 1;
      n = 0;
      while (bus_off && n < 60000) begin
         step($urandom % 2, ($urandom % 16) != 0, ($urandom % 20) == 0,
              ($urandom % 40) == 0, $urandom % 2);
         n++;
      end
      chk("R7 recovery completes", int'(bus_off), 0);
      chk("R7 run count", pulses - p0, 129);
      chk("R8 bus_en follows flag", int'(bus_en), int'(!init_flag));

      // continuous recessive: count samples to exit (R7), with writes (R8)
      step(0, 1, 1, 0, 0);
      step(0, 1, 0, 1, 0);
      n = 0;
      while (bus_off && n < 3000) begin
         step(1, 1, 0, (n % 300) == 5, (n % 600) == 5);
         n++;
      end
      chk("R7 samples to exit", n, 1419);
      chk("R8 final flag bus_en", int'(bus_en), int'(!init_flag));

      // normal operation random
      for (int i = 0; i < 200; i++)
         step($urandom % 2, $urandom % 2, ($urandom % 50) == 0, ($urandom % 4) == 0, $urandom % 2);
      finish_run();
   end
endmodule